// File: doc/BRIEF.md
# Flash Block Erase Sequencer

This block is the control state machine that walks software through a block erase of an embedded flash array. It holds the control bits, the block select and lock masks, a one-shot interlock detector on the array write strobe, and a cycle counter that stands in for the analog erase time. Software puts the block into erase mode and picks the blocks. It makes a single throw-away write to the array, then raises the high-voltage enable. It then polls the done flag, reads the pass flag, and drops the bits again.

A block is erased only if it is selected and not locked. The two masks are separate registers and neither one overrides the other. If the enable is dropped while an erase is running, the erase is aborted with a fail status, and the affected blocks are marked indeterminate until a later erase of those blocks succeeds. An external suspend input freezes the erase timer and blocks any abort while it is high.

Top module: `fes_ctrl`

## Requirements
- R1: After reset, the control register (address 0) reads 0x04: only DONE is set. The select (address 1), lock (address 2), erased-mask (address 3) and indeterminate-mask (address 4) registers all read 0. Control bit positions: MODE=0, HVEN=1, DONE=2, PASS=3, SHADOW=4, ILOCK=5; all other bits read 0.
- R2: While MODE is 1 and ILOCK is 0, an array write sets ILOCK and copies `shadow_en` into SHADOW. The data of that write is discarded. Further array writes are ignored until ILOCK clears, and array writes made outside erase mode change nothing.
- R3: A write of HVEN=1 takes effect only when MODE and ILOCK are both already 1. Otherwise HVEN stays 0, although MODE=1 in the same write still enters erase mode.
- R4: When HVEN is set and the effective mask (select AND NOT lock) is non-empty, DONE and PASS read 0 during the erase. Exactly ERASE_CYC clock edges after the write edge, DONE and PASS go to 1.
- R5: A successful erase sets the erased-mask bits and clears the indeterminate-mask bits of exactly the blocks that are selected and not locked. Blocks that are locked or unselected are left unchanged.
- R6: If the effective mask is empty when HVEN is set, DONE stays 1 and PASS reads 1 on the next cycle.
- R7: Writing MODE=0 while HVEN is 0 leaves erase mode, clears ILOCK and erases nothing.
- R8: While HVEN is 1, writes that clear MODE are ignored, and writes to the select and lock registers are ignored.
- R9: Clearing HVEN while an erase runs with suspend low aborts it. On the next cycle HVEN is 0, DONE is 1 and PASS is 0, and the blocks being erased are cleared from the erased mask and set in the indeterminate mask.
- R10: While `susp_in` is 1, an abort attempt is ignored (HVEN stays 1 and DONE stays 0) and the erase timer does not advance. After release, the erase completes ERASE_CYC edges later.
- R11: Clearing HVEN also clears ILOCK, so each further erase needs a new interlock write. Erasing indeterminate blocks again restores them to erased.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address for write and read |
| reg_wdata | input | NUM_BLK | Register write data |
| reg_rdata | output | NUM_BLK | Register read data (combinational) |
| arr_wr | input | 1 | Array write strobe (interlock candidate) |
| shadow_en | input | 1 | Shadow-enable level captured by the interlock write |
| susp_in | input | 1 | Erase suspend status |
| done_o | output | 1 | Erase done flag |
| pass_o | output | 1 | Erase pass flag |

## Verification
The bench first tries HVEN before any interlock write and after a completed erase. A design that does not re-arm the interlock would start an erase here. It samples DONE one edge before and exactly at the ERASE_CYC boundary, so an off-by-one timer shows up. Selected-and-locked blocks are checked to stay unerased, and an abort must leave PASS at 0 with the blocks marked indeterminate. An abort attempt during suspend is followed by a long wait. A design that honours that abort, or keeps counting while suspended, would show DONE early or HVEN dropped.

// File: rtl/fes_pkg.sv
`timescale 1ns/1ps
package fes_pkg;

    typedef enum logic [2:0] {
        RA_CTRL   = 3'd0,
        RA_SEL    = 3'd1,
        RA_LOCK   = 3'd2,
        RA_ERASED = 3'd3,
        RA_INDET  = 3'd4
    } reg_addr_e;

    // Write-data bit positions inside the control register
    localparam int WB_MODE = 0;
    localparam int WB_HVEN = 1;

    // Packed so that mode lands on bit 0 and ilock on bit 5
    typedef struct packed {
        logic ilock;
        logic shadow;
        logic pass;
        logic done;
        logic hven;
        logic mode;
    } ctl_stat_t;

    localparam int CTL_W = $bits(ctl_stat_t);

    // Decoded control-register write intent
    typedef struct packed {
        logic enter;
        logic leave;
        logic start;
        logic drop;
    } ctl_cmd_t;

endpackage

// File: rtl/fes_timer.sv
`timescale 1ns/1ps
module fes_timer #(
    parameter int ECYC = 64
) (
    input  logic clk,
    input  logic rst,
    input  logic load,
    input  logic en,
    output logic zero
);
    localparam int CW = (ECYC > 2) ? $clog2(ECYC) : 1;
    localparam logic [CW-1:0] TOP = CW'(ECYC - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (load)
            cnt_q <= TOP;
        else if (en && cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign zero = (cnt_q == '0);
endmodule

// File: rtl/fes_blkmap.sv
`timescale 1ns/1ps
module fes_blkmap #(
    parameter int NB = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          commit,
    input  logic          abort,
    input  logic [NB-1:0] mask,
    output logic [NB-1:0] erased,
    output logic [NB-1:0] indet
);
    for (genvar b = 0; b < NB; b++) begin : g_blk
        logic er_q, in_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                er_q <= 1'b0;
                in_q <= 1'b0;
            end else if (mask[b]) begin
                if (commit) begin
                    er_q <= 1'b1;
                    in_q <= 1'b0;
                end else if (abort) begin
                    er_q <= 1'b0;
                    in_q <= 1'b1;
                end
            end
        end
        assign erased[b] = er_q;
        assign indet[b]  = in_q;
    end
endmodule

// File: rtl/fes_seq.sv
`timescale 1ns/1ps
module fes_seq
    import fes_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      ctl_wr,
    input  logic      wd_mode,
    input  logic      wd_hv,
    input  logic      arr_wr,
    input  logic      shadow_en,
    input  logic      susp,
    input  logic      eff_empty,
    input  logic      tmr_zero,
    output ctl_stat_t st,
    output logic      tmr_load,
    output logic      tmr_en,
    output logic      commit,
    output logic      abort
);
    logic mode_q, hv_q, busy_q, pass_q, shad_q, ilk_q;
    ctl_cmd_t cmd;
    logic release_hv, finish, take_ilk;

    always_comb begin
        cmd.enter  = ctl_wr && !mode_q && wd_mode;
        cmd.leave  = ctl_wr && mode_q && !hv_q && !wd_mode;
        cmd.start  = ctl_wr && mode_q && !hv_q && ilk_q && wd_mode && wd_hv;
        cmd.drop   = ctl_wr && hv_q && !wd_hv;
        abort      = cmd.drop && busy_q && !susp;
        release_hv = cmd.drop && !busy_q;
        finish     = busy_q && !susp && tmr_zero && !abort;
        take_ilk   = arr_wr && mode_q && !ilk_q;
    end

    assign tmr_load = cmd.start && !eff_empty;
    assign tmr_en   = busy_q && !susp;
    assign commit   = finish;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= 1'b0;
            hv_q   <= 1'b0;
            busy_q <= 1'b0;
            pass_q <= 1'b0;
            shad_q <= 1'b0;
            ilk_q  <= 1'b0;
        end else begin
            if (take_ilk) begin
                ilk_q  <= 1'b1;
                shad_q <= shadow_en;
            end
            if (cmd.enter) begin
                mode_q <= 1'b1;
                ilk_q  <= 1'b0;
            end
            if (cmd.leave) begin
                mode_q <= 1'b0;
                ilk_q  <= 1'b0;
            end
            if (cmd.start) begin
                hv_q   <= 1'b1;
                busy_q <= !eff_empty;
                pass_q <= eff_empty;
            end
            if (abort) begin
                hv_q   <= 1'b0;
                busy_q <= 1'b0;
                pass_q <= 1'b0;
                ilk_q  <= 1'b0;
            end
            if (release_hv) begin
                hv_q  <= 1'b0;
                ilk_q <= 1'b0;
            end
            if (finish) begin
                busy_q <= 1'b0;
                pass_q <= 1'b1;
            end
        end
    end

    always_comb begin
        st.mode   = mode_q;
        st.hven   = hv_q;
        st.done   = !busy_q;
        st.pass   = pass_q;
        st.shadow = shad_q;
        st.ilock  = ilk_q;
    end
endmodule

// File: rtl/fes_ctrl.sv
`timescale 1ns/1ps
module fes_ctrl
    import fes_pkg::*;
#(
    parameter int NUM_BLK   = 8,
    parameter int ERASE_CYC = 64
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               reg_wr,
    input  logic [2:0]         reg_addr,
    input  logic [NUM_BLK-1:0] reg_wdata,
    output logic [NUM_BLK-1:0] reg_rdata,
    input  logic               arr_wr,
    input  logic               shadow_en,
    input  logic               susp_in,
    output logic               done_o,
    output logic               pass_o
);
    ctl_stat_t          st;
    logic [NUM_BLK-1:0] sel_q, lock_q, eff, erased, indet;
    logic               tmr_load, tmr_en, tmr_zero, commit, abort;
    logic               wr_ctl, wr_sel, wr_lock;

    assign wr_ctl  = reg_wr && reg_addr_e'(reg_addr) == RA_CTRL;
    assign wr_sel  = reg_wr && reg_addr_e'(reg_addr) == RA_SEL  && !st.hven;
    assign wr_lock = reg_wr && reg_addr_e'(reg_addr) == RA_LOCK && !st.hven;

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q  <= '0;
            lock_q <= '0;
        end else begin
            if (wr_sel)  sel_q  <= reg_wdata;
            if (wr_lock) lock_q <= reg_wdata;
        end
    end

    assign eff = sel_q & ~lock_q;

    fes_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .ctl_wr    (wr_ctl),
        .wd_mode   (reg_wdata[WB_MODE]),
        .wd_hv     (reg_wdata[WB_HVEN]),
        .arr_wr    (arr_wr),
        .shadow_en (shadow_en),
        .susp      (susp_in),
        .eff_empty (eff == '0),
        .tmr_zero  (tmr_zero),
        .st        (st),
        .tmr_load  (tmr_load),
        .tmr_en    (tmr_en),
        .commit    (commit),
        .abort     (abort)
    );

    fes_timer #(.ECYC(ERASE_CYC)) u_tmr (
        .clk  (clk),
        .rst  (rst),
        .load (tmr_load),
        .en   (tmr_en),
        .zero (tmr_zero)
    );

    fes_blkmap #(.NB(NUM_BLK)) u_map (
        .clk    (clk),
        .rst    (rst),
        .commit (commit),
        .abort  (abort),
        .mask   (eff),
        .erased (erased),
        .indet  (indet)
    );

    always_comb begin
        case (reg_addr_e'(reg_addr))
            RA_CTRL:   reg_rdata = NUM_BLK'(st);
            RA_SEL:    reg_rdata = sel_q;
            RA_LOCK:   reg_rdata = lock_q;
            RA_ERASED: reg_rdata = erased;
            RA_INDET:  reg_rdata = indet;
            default:   reg_rdata = '0;
        endcase
    end

    assign done_o = st.done;
    assign pass_o = st.pass;
endmodule

// File: rtl/fes_ctrl_chk.sv
`timescale 1ns/1ps
module fes_ctrl_chk
    import fes_pkg::*;
#(
    parameter int NUM_BLK = 8
) (
    input logic               clk,
    input logic               rst,
    input logic               reg_wr,
    input logic [2:0]         reg_addr,
    input logic [NUM_BLK-1:0] reg_wdata,
    input logic               susp_in,
    input logic               done_o,
    input logic               pass_o,
    input ctl_stat_t          st
);
    initial a_r1_width_fits: assert (NUM_BLK >= CTL_W);

    a_r3_start_needs_ilock: assert property (@(posedge clk) disable iff (rst)
        (st.hven && !$past(st.hven)) |-> ($past(st.ilock) && $past(st.mode)));

    a_r8_mode_kept: assert property (@(posedge clk) disable iff (rst)
        st.hven |-> st.mode);

    a_r4_running_not_pass: assert property (@(posedge clk) disable iff (rst)
        !done_o |-> (!pass_o && st.hven));

    a_r9_abort_fails: assert property (@(posedge clk) disable iff (rst)
        ($past(reg_wr) && $past(reg_addr) == 3'd0 && !$past(reg_wdata[WB_HVEN])
         && $past(st.hven) && !$past(done_o) && !$past(susp_in))
        |-> (!st.hven && done_o && !pass_o));

    a_r10_suspend_holds: assert property (@(posedge clk) disable iff (rst)
        ($past(susp_in) && $past(st.hven) && !$past(done_o)) |-> (st.hven && !done_o));
endmodule

bind fes_ctrl fes_ctrl_chk #(.NUM_BLK(NUM_BLK)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .susp_in   (susp_in),
    .done_o    (done_o),
    .pass_o    (pass_o),
    .st        (st)
);

// File: tb/sim_fes_ctrl.sv
`timescale 1ns/1ps
module sim_fes_ctrl;
    localparam int NB = 8;
    localparam int EC = 64;
    localparam int PORTS = 7;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #5 clk = ~clk;

    logic          reg_wr = 1'b0;
    logic [2:0]    drv_addr = '0;
    logic [2:0]    mon_addr = '0;
    logic          mon_sel = 1'b0;
    logic [2:0]    reg_addr;
    logic [NB-1:0] reg_wdata = '0;
    logic [NB-1:0] reg_rdata;
    logic          arr_wr = 1'b0, shadow_en = 1'b0, susp_in = 1'b0;
    logic          done_o, pass_o;

    assign reg_addr = mon_sel ? mon_addr : drv_addr;

    fes_ctrl #(.NUM_BLK(NB), .ERASE_CYC(EC)) u0 (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .arr_wr(arr_wr),
        .shadow_en(shadow_en), .susp_in(susp_in), .done_o(done_o), .pass_o(pass_o)
    );

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int n_run = 0, n_fail = 0;
    bit ended = 1'b0;

    // scoreboard queues
    int            addr_q[$];
    logic [NB-1:0] exp_q[$];
    string         tag_q[$];

    // monitor: pops expected items and compares against the design
    initial forever begin
        while (addr_q.size() == 0) #1;
        mon_addr = 3'(addr_q[0]);
        mon_sel  = (addr_q[0] != PORTS);
        #1;
        begin
            logic [NB-1:0] got;
            got = (addr_q[0] == PORTS) ? NB'({pass_o, done_o}) : reg_rdata;
            n_run++;
            if (got !== exp_q[0]) begin
                n_fail++;
                $display("FAIL %s: addr %0d actual %h expected %h", tag_q[0], addr_q[0], got, exp_q[0]);
            end
        end
        mon_sel = 1'b0;
        void'(addr_q.pop_front());
        void'(exp_q.pop_front());
        void'(tag_q.pop_front());
    end

    task automatic expect_val(input int a, input logic [NB-1:0] e, input string tag);
        addr_q.push_back(a);
        exp_q.push_back(e);
        tag_q.push_back(tag);
        while (addr_q.size() != 0) #1;
    endtask

    task automatic wr(input logic [2:0] a, input logic [NB-1:0] d);
        @(negedge clk);
        drv_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic awr(input logic sh);
        @(negedge clk);
        shadow_en = sh; reg_wdata = 8'hA5; arr_wr = 1'b1;
        @(negedge clk);
        arr_wr = 1'b0; shadow_en = 1'b0;
    endtask

    task automatic wait_to(input int n);
        while (cyc < n) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!ended) begin
            ended = 1'b1;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        int s;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        expect_val(0, 8'h04, "R1 ctrl");
        expect_val(1, 8'h00, "R1 select");
        expect_val(2, 8'h00, "R1 lock");
        expect_val(3, 8'h00, "R1 erased");
        expect_val(4, 8'h00, "R1 indet");
        expect_val(PORTS, 8'h01, "R1 ports done");

        // R2 array write outside mode is ignored
        awr(1'b1);
        expect_val(0, 8'h04, "R2 no mode");

        // R3 HVEN before interlock ignored
        wr(0, 8'h01);
        wr(0, 8'h03);
        expect_val(0, 8'h05, "R3 no ilock");

        // R2 interlock capture, second write ignored
        wr(1, 8'h0F);
        wr(2, 8'h05);
        awr(1'b1);
        expect_val(0, 8'h35, "R2 interlock");
        awr(1'b0);
        expect_val(0, 8'h35, "R2 second write");

        // R4 start, R8 protection
        wr(0, 8'h03);
        s = cyc;
        expect_val(0, 8'h33, "R4 running");
        expect_val(PORTS, 8'h00, "R4 ports running");
        wr(1, 8'hFF);
        expect_val(1, 8'h0F, "R8 select protected");
        wr(0, 8'h02);
        expect_val(0, 8'h33, "R8 mode kept");
        wait_to(s + EC - 1);
        expect_val(0, 8'h33, "R4 one before end");
        wait_to(s + EC);
        expect_val(0, 8'h3F, "R4 done");
        expect_val(3, 8'h0A, "R5 select and not lock");
        expect_val(4, 8'h00, "R5 indet");

        // R11 release clears interlock
        wr(0, 8'h01);
        expect_val(0, 8'h1D, "R11 released");
        wr(0, 8'h03);
        expect_val(0, 8'h1D, "R11 needs new interlock");

        // R9 abort
        wr(1, 8'h30);
        wr(2, 8'h00);
        awr(1'b0);
        expect_val(0, 8'h2D, "R9 armed");
        wr(0, 8'h03);
        expect_val(0, 8'h23, "R9 running");
        repeat (5) @(negedge clk);
        wr(0, 8'h01);
        expect_val(0, 8'h05, "R9 aborted");
        expect_val(4, 8'h30, "R9 indet");
        expect_val(3, 8'h0A, "R9 erased");

        // R10 suspend blocks abort and freezes timer
        awr(1'b0);
        wr(0, 8'h03);
        susp_in = 1'b1;
        wr(0, 8'h01);
        expect_val(0, 8'h23, "R10 abort ignored");
        repeat (100) @(negedge clk);
        expect_val(0, 8'h23, "R10 frozen");
        susp_in = 1'b0;
        s = cyc;
        wait_to(s + EC - 1);
        expect_val(0, 8'h23, "R10 one before end");
        wait_to(s + EC);
        expect_val(0, 8'h2F, "R10 done");
        expect_val(3, 8'h3A, "R11 re-erased");
        expect_val(4, 8'h00, "R11 indet cleared");

        // R7 terminate before start
        wr(0, 8'h01);
        expect_val(0, 8'h0D, "R7 released");
        wr(0, 8'h00);
        expect_val(0, 8'h0C, "R7 left");
        wr(0, 8'h01);
        awr(1'b1);
        expect_val(0, 8'h3D, "R7 armed");
        wr(1, 8'hC0);
        wr(0, 8'h00);
        expect_val(0, 8'h1C, "R7 terminated");
        expect_val(3, 8'h3A, "R7 nothing erased");
        wr(0, 8'h03);
        expect_val(0, 8'h1D, "R3 mode only");

        // R6 empty effective mask
        wr(1, 8'h01);
        wr(2, 8'h01);
        awr(1'b0);
        expect_val(0, 8'h2D, "R6 armed");
        wr(0, 8'h03);
        expect_val(0, 8'h2F, "R6 immediate pass");
        expect_val(3, 8'h3A, "R5 locked not erased");

        ended = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule